// File: doc/BRIEF.md
# 40-bit Multiply-Accumulate Unit

This block is a coprocessor datapath built around one 40-bit signed accumulator. Each command carries an opcode and two 32-bit register operands. The halfword-select field is used only by the single 16x16 form. Three multiply-accumulate forms are available:

- a 16x16 product, where the halfword of each operand is chosen by the select field;
- a dual 16x16 form, which adds the upper-half product and the lower-half product together;
- a 32x32 form, which adds only the low 40 bits of the 64-bit product.

A load command joins two registers into the accumulator. The accumulator is always visible as two 32-bit output words, so copying it out to two registers is a plain read of those outputs.

Commands arrive on a valid/ready stream. A command is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The sender must hold the command steady while `in_valid` is high and `in_ready` is low. The halfword forms and the load finish at the edge that accepts them. The 32x32 form needs a second edge, and `in_ready` is low for the cycle between the two edges. `done` is a plain status pulse with no back-pressure. Arithmetic wraps modulo 2^40.

Top module: `mac40_unit`

## Requirements
- R1: After reset the accumulator is zero, `acc_lo` and `acc_hi` read 0, `in_ready` is 1 and `done` is 0.
- R2: Opcode 2'b00 (halfword form) takes the upper half of `in_a` when `in_hsel[1]`=1 and its lower half otherwise. It takes the upper half of `in_b` when `in_hsel[0]`=1 and its lower half otherwise. The two halves are multiplied as signed values, the 32-bit product is sign-extended to 40 bits, and the result is added to the accumulator at the accepting edge.
- R3: Opcode 2'b01 (dual form) adds two sign-extended products to the accumulator at the accepting edge. One is the signed product of the upper halves of `in_a` and `in_b`; the other is the signed product of their lower halves.
- R4: Opcode 2'b10 (word form) forms the signed 32x32 product and adds its low 40 bits to the accumulator one clock edge after the accepting edge.
- R5: In the cycle after a word-form command is accepted, `in_ready` is 0 and `done` is 0. A command held on the input during that cycle is not taken.
- R6: Opcode 2'b11 (load) sets accumulator bits 31:0 from `in_a` and bits 39:32 from `in_b[7:0]`. The remaining bits of `in_b` are ignored.
- R7: `acc_lo` equals accumulator bits 31:0. `acc_hi` equals accumulator bits 39:32, sign-extended to 32 bits.
- R8: Accumulation wraps modulo 2^40 with no saturation.
- R9: `done` is 1 for exactly the cycle after an operation completes. That is the cycle after the accepting edge for the halfword, dual and load commands, and the cycle after the second edge for the word form.
- R10: When no command is accepted and no word-form operation is pending, the accumulator keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Unit can take a command |
| in_op | input | 2 | Opcode: 00 halfword, 01 dual, 10 word, 11 load |
| in_a | input | 32 | First operand (low word for load) |
| in_b | input | 32 | Second operand (high word for load) |
| in_hsel | input | 2 | Halfword select: bit 1 for `in_a`, bit 0 for `in_b` |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| acc_hi | output | 32 | Accumulator bits 39:32, sign-extended |
| done | output | 1 | Operation completed in the previous cycle |

## Verification
The assertions assume that the sender never drives `in_valid` with an unknown opcode, and that it holds a command steady while `in_ready` is low. The stimulus raises and lowers `in_valid` only at falling edges. When a word-form command stalls, the stimulus deliberately keeps that same command on the input through the stall cycle and withdraws it once `in_ready` returns. That exercises back-pressure without breaking the hold rule. The operand sweeps combine the extreme signed halfword and word values, and load commands preset the accumulator near both wrap boundaries.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
  typedef enum logic [1:0] {
    OP_HALF = 2'b00,
    OP_DUAL = 2'b01,
    OP_WORD = 2'b10,
    OP_LOAD = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac40_half_term.sv
module mac40_half_term
  import mac40_pkg::*;
#(
  parameter int OP_W  = 32,
  parameter int ACC_W = 40
) (
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  input  logic [1:0]       hsel,
  input  mac_op_e          op,
  output logic [ACC_W-1:0] addend
);
  localparam int HALF_W = OP_W / 2;
  localparam int EXT_W  = ACC_W - OP_W;

  logic signed [OP_W-1:0] lane_p [2];

  // lane 0: low halves, lane 1: high halves
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [HALF_W-1:0] la, lb;
    assign la = a[g*HALF_W +: HALF_W];
    assign lb = b[g*HALF_W +: HALF_W];
    assign lane_p[g] = la * lb;
  end

  logic signed [HALF_W-1:0] sa, sb;
  logic signed [OP_W-1:0]   sel_p;
  logic [ACC_W-1:0]         ext0, ext1, ext_sel;

  always_comb begin
    sa      = hsel[1] ? a[OP_W-1:HALF_W] : a[HALF_W-1:0];
    sb      = hsel[0] ? b[OP_W-1:HALF_W] : b[HALF_W-1:0];
    sel_p   = sa * sb;
    ext0    = {{EXT_W{lane_p[0][OP_W-1]}}, lane_p[0]};
    ext1    = {{EXT_W{lane_p[1][OP_W-1]}}, lane_p[1]};
    ext_sel = {{EXT_W{sel_p[OP_W-1]}}, sel_p};
    addend  = (op == OP_DUAL) ? ext0 + ext1 : ext_sel;
  end
endmodule

// File: rtl/mac40_wide_stage.sv
module mac40_wide_stage #(
  parameter int OP_W  = 32,
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  output logic             busy,
  output logic [ACC_W-1:0] prod
);
  localparam int EXT_W = ACC_W - OP_W;

  // low ACC_W bits of a signed product only need ACC_W-wide operands
  logic signed [ACC_W-1:0] ax, bx, px;

  always_comb begin
    ax = {{EXT_W{a[OP_W-1]}}, a};
    bx = {{EXT_W{b[OP_W-1]}}, b};
    px = ax * bx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      prod <= '0;
    end else begin
      busy <= start;
      if (start) prod <= px;
    end
  end

  // R4
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
endmodule

// File: rtl/mac40_acc_reg.sv
module mac40_acc_reg #(
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [ACC_W-1:0] ld_val,
  input  logic             add,
  input  logic [ACC_W-1:0] add_val,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (ld)  acc <= ld_val;
    else if (add) acc <= acc + add_val;
  end

  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !add) |=> $stable(acc));

  // R6
  ld_add_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld && add));
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int OP_W  = 32,
  parameter int ACC_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_op,
  input  logic [OP_W-1:0] in_a,
  input  logic [OP_W-1:0] in_b,
  input  logic [1:0]      in_hsel,
  output logic [OP_W-1:0] acc_lo,
  output logic [OP_W-1:0] acc_hi,
  output logic            done
);
  localparam int TOP_W = ACC_W - OP_W;
  localparam int PAD_W = 2 * OP_W - ACC_W;

  mac_op_e          op;
  logic             accept, start_word, busy, single, ld, add;
  logic [ACC_W-1:0] half_add, wide_prod, add_val, ld_val, acc;

  always_comb begin
    op         = mac_op_e'(in_op);
    in_ready   = !busy;
    accept     = in_valid && in_ready;
    start_word = accept && (op == OP_WORD);
    single     = accept && (op != OP_WORD);
    ld         = accept && (op == OP_LOAD);
    add        = busy || (accept && (op == OP_HALF || op == OP_DUAL));
    add_val    = busy ? wide_prod : half_add;
    ld_val     = {in_b[TOP_W-1:0], in_a};
  end

  mac40_half_term #(.OP_W(OP_W), .ACC_W(ACC_W)) u_half (
    .a(in_a), .b(in_b), .hsel(in_hsel), .op(op), .addend(half_add)
  );

  mac40_wide_stage #(.OP_W(OP_W), .ACC_W(ACC_W)) u_wide (
    .clk(clk), .rst_n(rst_n), .start(start_word), .a(in_a), .b(in_b),
    .busy(busy), .prod(wide_prod)
  );

  mac40_acc_reg #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val),
    .add(add), .add_val(add_val), .acc(acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= single || busy;
  end

  assign acc_lo = acc[OP_W-1:0];
  assign acc_hi = {{PAD_W{acc[ACC_W-1]}}, acc[ACC_W-1:OP_W]};

  // R5
  word_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_word |=> (!in_ready && !done));

  // R9
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    single |=> done);

  // R9
  word_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && in_ready));

  // R6
  load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (acc_lo == $past(in_a) && acc_hi[TOP_W-1:0] == $past(in_b[TOP_W-1:0])));
endmodule

// File: tb/mac40_unit_tb.sv
module mac40_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [31:0] in_a = '0, in_b = '0;
  logic [1:0]  in_hsel = 2'b00;
  logic [31:0] acc_lo, acc_hi;
  logic        done;

  int checks = 0;
  int fails  = 0;
  logic [39:0] m = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  mac40_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_hsel(in_hsel),
    .acc_lo(acc_lo), .acc_hi(acc_hi), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_acc(input string req);
    logic [63:0] exp = {{24{m[39]}}, m[39:32], m[31:0]};
    chk({acc_hi, acc_lo} == exp, req, {acc_hi, acc_lo}, exp);
  endtask

  function automatic logic [39:0] sx(input logic [31:0] p);
    return {{8{p[31]}}, p};
  endfunction

  function automatic logic [31:0] hmul(input logic [15:0] x, input logic [15:0] y);
    longint r = longint'($signed(x)) * longint'($signed(y));
    return r[31:0];
  endfunction

  // single-cycle command: drive at a falling edge, sample at the next one
  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, input logic [1:0] hs);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_hsel = hs;
    @(negedge clk);
    case (op)
      2'b00: m = m + sx(hmul(hs[1] ? a[31:16] : a[15:0], hs[0] ? b[31:16] : b[15:0]));
      2'b01: m = m + sx(hmul(a[31:16], b[31:16])) + sx(hmul(a[15:0], b[15:0]));
      default: m = {b[7:0], a};
    endcase
  endtask

  task automatic issue_word(input logic [31:0] a, input logic [31:0] b);
    longint p;
    in_valid = 1'b1; in_op = 2'b10; in_a = a; in_b = b; in_hsel = 2'b00;
    @(negedge clk);
    chk(in_ready == 1'b0 && done == 1'b0, "R5 stall", {62'd0, in_ready, done}, 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    p = longint'($signed(a)) * longint'($signed(b));
    m = m + p[39:0];
    chk_acc("R4 word product");
    chk(done == 1'b1, "R9 word done", {63'd0, done}, 64'd1);
  endtask

  logic [15:0] hv [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
  logic [31:0] wv [6] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h12345678};

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk_acc("R1 reset acc");
    chk(in_ready == 1'b1 && done == 1'b0, "R1 reset flags", {62'd0, in_ready, done}, 64'd2);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: halfword selections over edge values
    for (int hs = 0; hs < 4; hs++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++) begin
          issue(2'b00, {hv[i], hv[5-i]}, {hv[j], hv[(j+2)%6]}, hs[1:0]);
          chk_acc("R2 halfword mac");
        end
    chk(done == 1'b1, "R9 single done", {63'd0, done}, 64'd1);

    // R3: dual form
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        issue(2'b01, {hv[i], hv[(i+3)%6]}, {hv[j], hv[5-j]}, 2'b00);
        chk_acc("R3 dual mac");
      end
    in_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R9 done drops", {63'd0, done}, 64'd0);

    // R10: idle cycles with changing inputs
    in_a = 32'hDEADBEEF; in_b = 32'h5555AAAA; in_op = 2'b11;
    repeat (3) @(negedge clk);
    chk_acc("R10 idle hold");

    // R4 / R5: word form
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) issue_word(wv[i], wv[j]);

    // R6 / R7: load, upper bits of in_b ignored
    issue(2'b11, 32'hCAFEF00D, 32'hABCDEF85, 2'b00);
    chk_acc("R6 load");
    chk(acc_hi == 32'hFFFFFF85, "R7 sign extend", {32'd0, acc_hi}, 64'hFFFFFF85);
    issue(2'b11, 32'h01234567, 32'hFFFFFF3A, 2'b00);
    chk(acc_hi == 32'h0000003A && acc_lo == 32'h01234567, "R7 positive", {acc_hi, acc_lo}, 64'h0000003A_01234567);

    // R8: wrap at both boundaries
    issue(2'b11, 32'hFFFFFFFF, 32'h0000007F, 2'b00);
    issue(2'b00, 32'h00000001, 32'h00000001, 2'b00);
    chk({acc_hi, acc_lo} == 64'hFFFFFF80_00000000, "R8 positive wrap", {acc_hi, acc_lo}, 64'hFFFFFF80_00000000);
    issue(2'b11, 32'hFFFFFFFF, 32'h000000FF, 2'b00);
    issue(2'b00, 32'h00000001, 32'h00000001, 2'b00);
    in_valid = 1'b0;
    chk({acc_hi, acc_lo} == 64'd0, "R8 zero wrap", {acc_hi, acc_lo}, 64'd0);
    chk_acc("R8 model");
    @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule